// File: doc/BRIEF.md
# Fetch-Snooping Scanline Interrupt

This block finds out where the picture processor is in its frame without a scanline input. It watches the processor's memory reads. The tile fetch at the end of each visible line reads the same nametable location three times in a row, and the block takes that as a line boundary. The first boundary in a frame puts the block into the in-frame state and clears its line counter. Each later boundary increments the counter. When the incremented count equals a target that the CPU has programmed, an interrupt becomes pending.

The block leaves the in-frame state in three cases: the picture bus stops issuing reads, the CPU fetches the non-maskable interrupt vector, or software switches rendering off. The CPU can read two registers. One holds the target. The other holds the pending and in-frame flags, and reading it acknowledges the interrupt. A small counter of pattern-table reads, cleared at each line boundary, is also brought out. Neighbouring logic uses it to place the sprite fetch window.

Everything runs on one clock. A picture-bus read is a one-cycle strobe sampled on that clock.

Top module: `scanline_snoop_irq`

## Requirements
- R1: A line event occurs when a nametable tile address is read three times in a row on consecutive picture-bus reads, on the edge of the third read. A nametable tile address has bit 13 = 1, bits 13:8 not equal to 0x3F, and bits 9:6 not equal to 0xF. Attribute reads (bits 9:6 = 0xF) and pattern reads (bit 13 = 0) never form an event. Further repeats of the same address after an event produce no new event.
- R2: Any picture-bus read that is not a repeat of the previous read's tile address resets the repeat count.
- R3: On a line event outside the frame, in-frame is set and the line counter is cleared to 0. On a line event inside the frame, the counter increments.
- R4: Pending is set when the incremented counter equals the target written at CPU address 0x5203. A target of 0 never sets pending.
- R5: `irq` is high exactly when pending is set and the enable is set. The enable is bit 7 of the last CPU write to 0x5204. Clearing the enable does not clear pending.
- R6: A CPU read of 0x5204 returns pending in bit 7, in-frame in bit 6 and zeros elsewhere, and clears pending after the read. A pending set in the same cycle wins over the clear. A read of 0x5203 returns the target. Reads of all other addresses return 0.
- R7: If three consecutive clocks pass with no picture-bus read, in-frame clears and the address history is forgotten. A repeat across such a gap does not match.
- R8: A CPU read of 0xFFFA or 0xFFFB clears in-frame and the history. So does a CPU write to 0x2001 whose bits 3 and 4 are both 0. These clears win over a line event in the same cycle.
- R9: `line_fetches` counts pattern reads (address bit 13 = 0), saturates at all ones, and returns to 0 on each line event.
- R10: After reset, the target, enable, pending, in-frame and counter are all 0, and the history holds no address. So the first reads after reset cannot match.
- R11: The line counter is DW bits wide and wraps from all ones to 0 without raising pending unless the target matches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ppu_rd | input | 1 | Picture-bus read strobe, one read per asserted cycle |
| ppu_addr | input | PPU_AW | Picture-bus address of the read |
| cpu_rd | input | 1 | CPU read strobe, including vector fetches |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | DW | CPU write data |
| cpu_rdata | output | DW | Register read data for the current CPU address |
| irq | output | 1 | Interrupt request, active high |
| line_fetches | output | FETCH_W | Pattern reads since the last line event |

## Verification
The bench builds the block with FETCH_W = 4 and leaves the other parameters at their defaults. With a 4-bit fetch counter, a single line of 20 pattern reads reaches the saturation corner of R9. The default 8-bit line counter and a three-cycle idle window keep the R11 wrap within a run of about 260 short lines, and keep the two- versus three-cycle gap of R7 inside a handful of clocks. Every clock compares the interrupt line, the fetch counter and any register read against a behavioural model.

// File: rtl/ssi_pkg.sv
// Package: CPU-side addresses and constants shared by the scanline snooper.
// Assumes a 16-bit CPU address bus.
package ssi_pkg;
    localparam logic [15:0] ADDR_TARGET  = 16'h5203;
    localparam logic [15:0] ADDR_STATUS  = 16'h5204;
    localparam logic [15:0] ADDR_RENDER  = 16'h2001;
    localparam logic [15:0] ADDR_NMI_LO  = 16'hFFFA;
    localparam logic [15:0] ADDR_NMI_HI  = 16'hFFFB;
    localparam int          RENDER_BIT_A = 3;
    localparam int          RENDER_BIT_B = 4;
    localparam int          ENABLE_BIT   = 7;
endpackage

// File: rtl/ssi_match_detect.sv
// Module: watches picture-bus reads for a tile address repeated three
// times (line event) and for three idle clocks (bus idle).
// Assumes one read per asserted ppu_rd cycle and IDLE_CYCLES >= 2.
module ssi_match_detect #(
    parameter int PPU_AW      = 14,
    parameter int IDLE_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ppu_rd,
    input  logic [PPU_AW-1:0] ppu_addr,
    input  logic              hist_clr,
    output logic              scan_evt,
    output logic              bus_idle
);
    localparam int IW = $clog2(IDLE_CYCLES + 1);

    logic [PPU_AW-1:0] prev_addr;
    logic              prev_vld;
    logic [1:0]        rep_cnt;
    logic [IW-1:0]     idle_cnt;
    logic              tile_nt;
    logic              hit;

    // Classify the current address as a nametable tile (not attribute) fetch.
    always_comb begin
        tile_nt = ppu_addr[PPU_AW-1]
                  && !(&ppu_addr[PPU_AW-1:8])
                  && !(&ppu_addr[9:6]);
        hit      = prev_vld && (prev_addr == ppu_addr) && tile_nt;
        scan_evt = ppu_rd && hit && (rep_cnt == 2'd1);
        bus_idle = !ppu_rd && (idle_cnt == IW'(IDLE_CYCLES - 1));
    end

    // Track the previous address and how many times it has repeated.
    always_ff @(posedge clk) begin
        if (!rst_n || hist_clr || bus_idle) begin
            prev_addr <= '0;
            prev_vld  <= 1'b0;
            rep_cnt   <= 2'd0;
        end else if (ppu_rd) begin
            prev_addr <= ppu_addr;
            prev_vld  <= 1'b1;
            if (!hit)
                rep_cnt <= 2'd0;
            else if (rep_cnt != 2'd2)
                rep_cnt <= rep_cnt + 2'd1;
        end
    end

    // Count consecutive clocks with no picture-bus read, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || ppu_rd)
            idle_cnt <= '0;
        else if (idle_cnt != IW'(IDLE_CYCLES))
            idle_cnt <= idle_cnt + 1'b1;
    end
endmodule

// File: rtl/ssi_line_counter.sv
// Module: in-frame flag, line counter and pending flag.
// Assumes frame_clr has priority over scan_evt in the same cycle.
module ssi_line_counter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scan_evt,
    input  logic          frame_clr,
    input  logic          ack,
    input  logic [DW-1:0] target,
    output logic          in_frame,
    output logic [DW-1:0] line_cnt,
    output logic          pending
);
    logic [DW-1:0] cnt_next;
    logic          tgt_hit;

    // Next count value and target comparison for an in-frame event.
    always_comb begin
        cnt_next = line_cnt + 1'b1;
        tgt_hit  = scan_evt && !frame_clr && in_frame
                   && (cnt_next == target) && (target != '0);
    end

    // Enter, advance or leave the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame <= 1'b0;
            line_cnt <= '0;
        end else if (frame_clr) begin
            in_frame <= 1'b0;
        end else if (scan_evt) begin
            if (!in_frame) begin
                in_frame <= 1'b1;
                line_cnt <= '0;
            end else begin
                line_cnt <= cnt_next;
            end
        end
    end

    // Pending flag: set on a target hit, cleared by an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (tgt_hit)
            pending <= 1'b1;
        else if (ack)
            pending <= 1'b0;
    end
endmodule

// File: rtl/ssi_fetch_counter.sv
// Module: counts pattern-table reads since the last line event.
// Assumes pattern reads are those with the top address bit clear.
module ssi_fetch_counter #(
    parameter int PPU_AW  = 14,
    parameter int FETCH_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ppu_rd,
    input  logic [PPU_AW-1:0]  ppu_addr,
    input  logic               scan_evt,
    output logic [FETCH_W-1:0] line_fetches
);
    // Saturating count, restarted at each line event.
    always_ff @(posedge clk) begin
        if (!rst_n || scan_evt)
            line_fetches <= '0;
        else if (ppu_rd && !ppu_addr[PPU_AW-1] && !(&line_fetches))
            line_fetches <= line_fetches + 1'b1;
    end
endmodule

// File: rtl/ssi_cpu_port.sv
// Module: CPU-side decode: target and enable registers, frame-clear
// strobes from vector fetches and rendering writes, and read data.
// Assumes DW >= 8 so that the enable and rendering bits exist.
module ssi_cpu_port #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_rd,
    input  logic          cpu_wr,
    input  logic [15:0]   cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          pending,
    input  logic          in_frame,
    output logic [DW-1:0] target,
    output logic          irq_en,
    output logic          nmi_fetch,
    output logic          render_off,
    output logic          ack,
    output logic [DW-1:0] cpu_rdata
);
    import ssi_pkg::*;

    // Decode strobes and select read data.
    always_comb begin
        nmi_fetch  = cpu_rd && ((cpu_addr == ADDR_NMI_LO) || (cpu_addr == ADDR_NMI_HI));
        render_off = cpu_wr && (cpu_addr == ADDR_RENDER)
                     && !cpu_wdata[RENDER_BIT_A] && !cpu_wdata[RENDER_BIT_B];
        ack        = cpu_rd && (cpu_addr == ADDR_STATUS);
        if (cpu_addr == ADDR_TARGET)
            cpu_rdata = target;
        else if (cpu_addr == ADDR_STATUS)
            cpu_rdata = {pending, in_frame, {(DW-2){1'b0}}};
        else
            cpu_rdata = '0;
    end

    // Target and enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target <= '0;
            irq_en <= 1'b0;
        end else if (cpu_wr) begin
            if (cpu_addr == ADDR_TARGET)
                target <= cpu_wdata;
            if (cpu_addr == ADDR_STATUS)
                irq_en <= cpu_wdata[ENABLE_BIT];
        end
    end
endmodule

// File: rtl/scanline_snoop_irq.sv
// Module: top of the fetch-snooping scanline interrupt.
// Assumes picture-bus reads and CPU accesses share clk.
module scanline_snoop_irq #(
    parameter int PPU_AW      = 14,
    parameter int DW          = 8,
    parameter int IDLE_CYCLES = 3,
    parameter int FETCH_W     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ppu_rd,
    input  logic [PPU_AW-1:0]  ppu_addr,
    input  logic               cpu_rd,
    input  logic               cpu_wr,
    input  logic [15:0]        cpu_addr,
    input  logic [DW-1:0]      cpu_wdata,
    output logic [DW-1:0]      cpu_rdata,
    output logic               irq,
    output logic [FETCH_W-1:0] line_fetches
);
    logic          scan_evt;
    logic          bus_idle;
    logic          nmi_fetch;
    logic          render_off;
    logic          hist_clr;
    logic          frame_clr;
    logic          ack;
    logic          in_frame;
    logic          pending;
    logic          irq_en;
    logic [DW-1:0] target;
    logic [DW-1:0] line_cnt;

    // Combine the frame-leave conditions.
    always_comb begin
        hist_clr  = nmi_fetch || render_off;
        frame_clr = hist_clr || bus_idle;
        irq       = pending && irq_en;
    end

    ssi_match_detect #(.PPU_AW(PPU_AW), .IDLE_CYCLES(IDLE_CYCLES)) match_i (
        .clk(clk), .rst_n(rst_n), .ppu_rd(ppu_rd), .ppu_addr(ppu_addr),
        .hist_clr(hist_clr), .scan_evt(scan_evt), .bus_idle(bus_idle)
    );

    ssi_line_counter #(.DW(DW)) line_i (
        .clk(clk), .rst_n(rst_n), .scan_evt(scan_evt), .frame_clr(frame_clr),
        .ack(ack), .target(target), .in_frame(in_frame), .line_cnt(line_cnt),
        .pending(pending)
    );

    ssi_fetch_counter #(.PPU_AW(PPU_AW), .FETCH_W(FETCH_W)) fetch_i (
        .clk(clk), .rst_n(rst_n), .ppu_rd(ppu_rd), .ppu_addr(ppu_addr),
        .scan_evt(scan_evt), .line_fetches(line_fetches)
    );

    ssi_cpu_port #(.DW(DW)) cpu_i (
        .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .pending(pending),
        .in_frame(in_frame), .target(target), .irq_en(irq_en),
        .nmi_fetch(nmi_fetch), .render_off(render_off), .ack(ack),
        .cpu_rdata(cpu_rdata)
    );
endmodule

// File: rtl/ssi_checker.sv
// Module: temporal checks on the scanline snooper, bound to its top.
// Assumes the signals named in the bind exist in scanline_snoop_irq.
module ssi_checker #(
    parameter int DW          = 8,
    parameter int IDLE_CYCLES = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ppu_rd,
    input logic          cpu_rd,
    input logic          cpu_wr,
    input logic [15:0]   cpu_addr,
    input logic          scan_evt,
    input logic          frame_clr,
    input logic          in_frame,
    input logic [DW-1:0] line_cnt,
    input logic          pending,
    input logic [DW-1:0] target
);
    localparam int QW = $clog2(IDLE_CYCLES + 1) + 1;
    logic [QW-1:0] quiet;

    // Count consecutive idle clocks seen since reset, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || ppu_rd)
            quiet <= '0;
        else if (quiet < QW'(IDLE_CYCLES))
            quiet <= quiet + 1'b1;
    end

    // R3: first event of a frame enters the frame at count zero
    a_r3_frame_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_evt && !in_frame && !frame_clr) |=> (in_frame && line_cnt == '0));

    // R11: an in-frame event steps the counter by one, wrapping
    a_r11_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_evt && in_frame && !frame_clr) |=> (line_cnt == DW'($past(line_cnt) + 1'b1)));

    // R4: a zero target never raises pending
    a_r4_zero_target_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending && target == '0) |=> !pending);

    // R6: a status read with no concurrent event acknowledges
    a_r6_read_acks: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr == 16'h5204 && !scan_evt) |=> !pending);

    // R7: three idle clocks leave no frame behind
    a_r7_idle_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet >= QW'(IDLE_CYCLES)) |-> !in_frame);

    // R8: vector fetch leaves the frame
    a_r8_vector_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && (cpu_addr == 16'hFFFA || cpu_addr == 16'hFFFB)) |=> !in_frame);

    // R8: rendering switched off leaves the frame
    a_r8_render_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == 16'h2001 && frame_clr) |=> !in_frame);
endmodule

bind scanline_snoop_irq ssi_checker #(.DW(DW), .IDLE_CYCLES(IDLE_CYCLES)) chk_i (
    .clk(clk), .rst_n(rst_n), .ppu_rd(ppu_rd), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .scan_evt(scan_evt), .frame_clr(frame_clr),
    .in_frame(in_frame), .line_cnt(line_cnt), .pending(pending), .target(target)
);

// File: tb/scanline_snoop_irq_tb_top.sv
// Bench: drives picture-bus and CPU traffic, compares against a
// behavioural model on every clock, and adds directed checks.
module scanline_snoop_irq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int FW         = 4;
    localparam int FMAX       = (1 << FW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ppu_rd = 1'b0;
    logic [13:0]   ppu_addr = '0;
    logic          cpu_rd = 1'b0;
    logic          cpu_wr = 1'b0;
    logic [15:0]   cpu_addr = '0;
    logic [7:0]    cpu_wdata = '0;
    logic [7:0]    cpu_rdata;
    logic          irq;
    logic [FW-1:0] line_fetches;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // Model state
    int m_prev = -1;
    int m_rep = 0, m_idle = 0, m_inf = 0, m_cnt = 0, m_pend = 0;
    int m_en = 0, m_tgt = 0, m_f = 0;

    scanline_snoop_irq #(.FETCH_W(FW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ppu_rd(ppu_rd), .ppu_addr(ppu_addr),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq),
        .line_fetches(line_fetches)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model, updated from the inputs present at each edge.
    always @(posedge clk) begin
        int a, d, ca;
        bit tile, hit, evt, idle_evt, nmi, roff, clr, ack, setp;
        a = int'(ppu_addr); d = int'(cpu_wdata); ca = int'(cpu_addr);
        if (!rst_n) begin
            m_prev = -1; m_rep = 0; m_idle = 0; m_inf = 0; m_cnt = 0;
            m_pend = 0; m_en = 0; m_tgt = 0; m_f = 0;
        end else begin
            tile = (a >= 'h2000) && (a < 'h3F00) && ((a & 'h3C0) != 'h3C0);
            hit  = ppu_rd && tile && (m_prev == a);
            evt  = hit && (m_rep == 1);
            idle_evt = !ppu_rd && (m_idle == 2);
            nmi  = cpu_rd && (ca == 'hFFFA || ca == 'hFFFB);
            roff = cpu_wr && ca == 'h2001 && (d & 'h18) == 0;
            clr  = idle_evt || nmi || roff;
            ack  = cpu_rd && ca == 'h5204;
            setp = 0;
            if (clr) m_inf = 0;
            else if (evt) begin
                if (m_inf == 0) begin m_inf = 1; m_cnt = 0; end
                else begin
                    m_cnt = (m_cnt + 1) % 256;
                    if (m_cnt == m_tgt && m_tgt != 0) setp = 1;
                end
            end
            if (setp) m_pend = 1; else if (ack) m_pend = 0;
            if (clr) begin m_prev = -1; m_rep = 0; end
            else if (ppu_rd) begin
                m_rep = hit ? ((m_rep == 2) ? 2 : m_rep + 1) : 0;
                m_prev = a;
            end
            m_idle = ppu_rd ? 0 : ((m_idle < 3) ? m_idle + 1 : 3);
            if (evt) m_f = 0;
            else if (ppu_rd && a < 'h2000 && m_f < FMAX) m_f++;
            if (cpu_wr && ca == 'h5203) m_tgt = d;
            if (cpu_wr && ca == 'h5204) m_en = (d >> 7) & 1;
        end
    end

    // One clock: drive inputs, compare before the edge, advance.
    task automatic step(bit rd, int pa, bit crd, bit cwr, int ca, int cd,
                        output int rdata);
        int exp_rd;
        ppu_rd = rd; ppu_addr = pa[13:0];
        cpu_rd = crd; cpu_wr = cwr; cpu_addr = ca[15:0]; cpu_wdata = cd[7:0];
        #1;
        rdata = int'(cpu_rdata);
        if (rst_n) begin
            check("R5 irq line", int'(irq), m_pend & m_en);
            check("R9 fetch count", int'(line_fetches), m_f);
            if (crd) begin
                if (ca == 'h5203) exp_rd = m_tgt;
                else if (ca == 'h5204) exp_rd = (m_pend << 7) | (m_inf << 6);
                else exp_rd = 0;
                check("R6 read data", rdata, exp_rd);
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ppu(int pa);
        int r; step(1, pa, 0, 0, 0, 0, r);
    endtask
    task automatic nop();
        int r; step(0, 0, 0, 0, 0, 0, r);
    endtask
    task automatic wr(int ca, int cd);
        int r; step(0, 0, 0, 1, ca, cd, r);
    endtask
    task automatic rd_exp(int ca, int exp, string tag);
        int r; step(0, 0, 1, 0, ca, 0, r); check(tag, r, exp);
    endtask
    // A status read while the picture bus stays busy.
    task automatic rd_busy(int ca, int exp, string tag);
        int r; step(1, 'h0100, 1, 0, ca, 0, r); check(tag, r, exp);
    endtask
    // One picture line: three identical tile reads then other fetches.
    task automatic line(int k);
        for (int i = 0; i < 3; i++) ppu('h2000 + (k % 'h3C0));
        ppu('h23C0);
        ppu('h0010);
        ppu('h0020);
        ppu('h2001 + (k % 'h3B0));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        for (int i = 0; i < 3; i++) nop();
        rst_n = 1'b1;
        // R10: reset state
        rd_exp('h5204, 'h00, "R10 status after reset");
        rd_exp('h5203, 'h00, "R10 target after reset");
        check("R10 irq after reset", int'(irq), 0);
        check("R10 fetch after reset", int'(line_fetches), 0);
        ppu('h2040); ppu('h2040);
        rd_busy('h5204, 'h00, "R10 two reads after reset no event");
        // R1: third identical tile read enters frame
        ppu('h2080); ppu('h2080); ppu('h2080);
        rd_busy('h5204, 'h40, "R1 event on third repeat");
        rd_exp('h1234, 'h00, "R6 other address reads zero");
        rd_exp('hFFFA, 'h00, "R8 vector fetch");
        rd_exp('h5204, 'h00, "R8 vector fetch cleared in-frame");
        // R1: attribute and pattern repeats never form events
        for (int i = 0; i < 4; i++) ppu('h23C8);
        rd_busy('h5204, 'h00, "R1 attribute repeat ignored");
        for (int i = 0; i < 4; i++) ppu('h0044);
        rd_busy('h5204, 'h00, "R1 pattern repeat ignored");
        // R2: interruption resets the repeat count
        ppu('h2100); ppu('h2100); ppu('h2101); ppu('h2100); ppu('h2100);
        rd_busy('h5204, 'h00, "R2 broken repeat no event");
        // R7: idle gap forgets history
        ppu('h2200); ppu('h2200); nop(); nop(); nop(); ppu('h2200);
        rd_busy('h5204, 'h00, "R7 history lost across idle gap");
        // R3/R4/R5: target 3 with interrupt enabled
        wr('h5203, 3); wr('h5204, 'h80);
        rd_exp('h5203, 3, "R6 target readback");
        line(0); line(1); line(2);
        rd_busy('h5204, 'h40, "R3 counting, not yet pending");
        line(3);
        check("R5 irq raised at target", int'(irq), 1);
        rd_busy('h5204, 'hC0, "R4 pending at target");
        rd_busy('h5204, 'h40, "R6 read acknowledged");
        check("R5 irq low after ack", int'(irq), 0);
        // R5: enable off masks irq, pending stays
        wr('h5203, 5);
        line(4); line(5);
        check("R5 irq with enable", int'(irq), 1);
        wr('h5204, 'h00);
        check("R5 irq masked", int'(irq), 0);
        rd_busy('h5204, 'hC0, "R5 pending kept when masked");
        // R8: rendering writes
        wr('h2001, 'h08);
        rd_busy('h5204, 'h40, "R8 rendering on keeps frame");
        wr('h2001, 'h00);
        rd_exp('h5204, 'h00, "R8 rendering off leaves frame");
        // R8: clear wins over a simultaneous event
        begin
            int r;
            ppu('h2300); ppu('h2300);
            step(1, 'h2300, 1, 0, 'hFFFB, 0, r);
        end
        rd_busy('h5204, 'h00, "R8 clear wins over event");
        // R7: two idle clocks keep frame, three leave
        line(6);
        nop(); nop(); ppu('h0100);
        rd_busy('h5204, 'h40, "R7 two idle clocks keep frame");
        nop(); nop(); nop();
        rd_exp('h5204, 'h00, "R7 three idle clocks leave frame");
        // R9: saturation and reset on event
        line(7);
        for (int i = 0; i < 20; i++) ppu('h0400 + i);
        check("R9 fetch saturates", int'(line_fetches), FMAX);
        ppu('h2010); ppu('h2010); ppu('h2010);
        check("R9 fetch cleared on event", int'(line_fetches), 0);
        // R11 and R4: zero target across a wrap, then a post-wrap target
        wr('h5204, 'h80); wr('h5203, 0);
        nop(); nop(); nop();
        line(8);
        for (int k = 0; k < 258; k++) line(9 + k);
        check("R4 zero target never fires", int'(irq), 0);
        wr('h5203, 3);
        rd_busy('h5204, 'h40, "R11 still in frame after wrap");
        line(300);
        rd_busy('h5204, 'hC0, "R11 wrapped count reaches target");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule